// File: doc/BRIEF.md
# Interpolating DAC Sample Sequencer

This block is the digital front end of a 12-bit digital-to-analog converter. Samples are written into a small internal FIFO from the bus side. A paced sequencer pulls them out and presents one 12-bit code at a time on its output, with an update strobe on each new value. The pace comes from a programmable divider of the block clock. Because samples are buffered, software can keep refilling the FIFO while playback runs, and playback continues without a gap.

There are three playback modes. Static mode holds a programmed code. Fixed-count mode plays a programmed number of FIFO samples and then stops with a done flag. Continuous mode plays for as long as the FIFO has data. An optional linear interpolator inserts intermediate codes between consecutive samples at a ratio of 2, 4 or 8 output steps per sample. If the FIFO runs dry during playback, the last code is held and a sticky underrun flag is raised. FIFO empty, full and below-threshold flags are brought out so that refills can be paced.

Top module: `dac_playout`

## Requirements
- R1: After reset, `code` is 0, `update`, `done` and `underrun` are 0, `fifoEmpty` is 1 and `fifoFull` is 0.
- R2: The FIFO holds 8 samples and returns them in write order. `fifoFull` is 1 at 8 entries and `fifoEmpty` is 1 at 0 entries. A write while full is dropped and never reaches the output.
- R3: `fifoLow` is 1 exactly when the number of stored samples is below `lowMark`.
- R4: With `playMode` 0 (static) and `enable` high, `code` follows `staticCode` one cycle later. No FIFO entry is consumed, and `update` stays 0.
- R5: During playback, consecutive `update` pulses are exactly `rateDiv`+1 clock cycles apart.
- R6: With `ratioSel` 0 (off), each `update` presents the next FIFO sample unchanged.
- R7: With `ratioSel` 1, 2 or 3 (N = 2, 4 or 8), each FIFO sample B produces N updates. Taking A as the code shown before B was taken, the code at step k = 1..N is A + ((B-A)·k >>> log2 N), using signed arithmetic shift. The last step therefore equals B.
- R8: With `playMode` 1 (fixed count), exactly `sampleCount` FIFO samples are played. `done` rises in the same cycle as the final update, and no update follows. With `sampleCount` 0, `done` rises with no update and no FIFO read.
- R9: With `playMode` 2 or 3 (continuous), playback continues while samples remain. A pacing slot that finds the FIFO empty sets `underrun` and holds `code`. Playback resumes at the next slot after new data arrives.
- R10: `underrun` and `done` stay set while `enable` is high and clear when `enable` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | FIFO write strobe |
| wrData | input | 12 | Sample written to the FIFO |
| enable | input | 1 | Run the sequencer; low stops playback and clears flags |
| playMode | input | 2 | 0 static, 1 fixed count, 2/3 continuous |
| staticCode | input | 12 | Code driven in static mode |
| sampleCount | input | 16 | Number of FIFO samples in fixed-count mode |
| rateDiv | input | 16 | Output step period minus one, in clocks |
| ratioSel | input | 2 | 0 off, 1 ratio 2, 2 ratio 4, 3 ratio 8 |
| lowMark | input | 4 | FIFO level threshold for `fifoLow` |
| code | output | 12 | Code to the converter |
| update | output | 1 | One-cycle pulse when a new playback code is presented |
| done | output | 1 | Fixed-count run finished |
| underrun | output | 1 | Sticky: a pacing slot found the FIFO empty |
| fifoEmpty | output | 1 | FIFO holds no samples |
| fifoFull | output | 1 | FIFO holds 8 samples |
| fifoLow | output | 1 | FIFO level below `lowMark` |

## Verification
The bench uses the default parameters: a 12-bit code, an 8-deep FIFO and 16-bit count and divider fields. It drives `rateDiv` with small values (1 to 3), so several full interpolation segments at every ratio fit in a few hundred cycles. Because the FIFO is 8 deep, it can be filled past full with a few writes, which tests the write-drop path, and drained to an underrun within one scenario. Interpolation runs include both rising and falling segments across the full code range, where the arithmetic shift rounds toward negative values.

// File: rtl/dac_playout_pkg.sv
package dac_playout_pkg;

  localparam int RATIO_SEL_W = 2;
  localparam int STEP_W      = RATIO_SEL_W + 2;

  typedef enum logic [1:0] {
    PM_STATIC = 2'd0,
    PM_COUNT  = 2'd1,
    PM_STREAM = 2'd2,
    PM_STREAM_ALT = 2'd3
  } playMode_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic              pop;        // take a new sample from the FIFO
    logic              step;       // present a new blended code
    logic [STEP_W-1:0] k;          // blend step index 1..N
    logic              loadStatic; // copy the static code
  } seqStrobe_t;

endpackage

// File: rtl/dac_playout_fifo.sv
module dac_playout_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [W-1:0]               wrData,
  input  logic                       rdEn,
  output logic [W-1:0]               rdData,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          accept, take;

  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign accept = wrEn && !full;
  assign take   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (accept) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (take)   rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({accept, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/dac_playout_ctrl.sv
module dac_playout_ctrl
  import dac_playout_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [1:0]             playMode,
  input  logic [CNT_W-1:0]       sampleCount,
  input  logic [DIV_W-1:0]       rateDiv,
  input  logic [RATIO_SEL_W-1:0] ratioSel,
  input  logic                   fifoEmpty,
  output seqStrobe_t             strobe,
  output logic                   done,
  output logic                   underrun
);
  localparam int PH_W = STEP_W - 1;

  logic              runR, run, tick;
  logic [DIV_W-1:0]  divCnt;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  popped;
  logic [STEP_W-1:0] ratio;
  logic              playback, counted, exhausted;
  logic              doneSet, underSet;

  always_comb begin
    run       = enable && runR;
    tick      = run && (divCnt == '0);
    playback  = (playMode != PM_STATIC);
    counted   = (playMode == PM_COUNT);
    ratio     = STEP_W'(1) << ratioSel;
    exhausted = counted && (popped == sampleCount);
    strobe    = '0;
    doneSet   = 1'b0;
    underSet  = 1'b0;
    strobe.loadStatic = enable && !playback;
    if (tick && playback && !done) begin
      if (phase == '0) begin
        if (exhausted) begin
          doneSet = 1'b1;
        end else if (fifoEmpty) begin
          underSet = 1'b1;
        end else begin
          strobe.pop  = 1'b1;
          strobe.step = 1'b1;
          strobe.k    = STEP_W'(1);
          if (ratio == STEP_W'(1) && counted && (popped + 1'b1 == sampleCount))
            doneSet = 1'b1;
        end
      end else begin
        strobe.step = 1'b1;
        strobe.k    = {1'b0, phase} + STEP_W'(1);
        if ((strobe.k == ratio) && exhausted) doneSet = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR     <= 1'b0;
      divCnt   <= '0;
      phase    <= '0;
      popped   <= '0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      runR <= enable;
      if (!run)               divCnt <= rateDiv;
      else if (divCnt == '0)  divCnt <= rateDiv;
      else                    divCnt <= divCnt - 1'b1;
      if (!enable) begin
        phase    <= '0;
        popped   <= '0;
        done     <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (doneSet)    done     <= 1'b1;
        if (underSet)   underrun <= 1'b1;
        if (strobe.pop) popped   <= popped + 1'b1;
        if (strobe.step)
          phase <= (strobe.k == ratio) ? '0 : phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_playout_dpath.sv
module dac_playout_dpath
  import dac_playout_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [RATIO_SEL_W-1:0] ratioSel,
  input  logic [W-1:0]           staticCode,
  input  logic [W-1:0]           rdData,
  output logic [W-1:0]           code,
  output logic                   update
);
  localparam int PW = W + STEP_W + 2;

  logic [W-1:0]         segA, segB, aNext, bNext;
  logic signed [W:0]    diff;
  logic signed [PW-1:0] prod, scaled, sum;
  logic [W-1:0]         blended;

  always_comb begin
    aNext   = strobe.pop ? code   : segA;
    bNext   = strobe.pop ? rdData : segB;
    diff    = $signed({1'b0, bNext}) - $signed({1'b0, aNext});
    prod    = diff * $signed({1'b0, strobe.k});
    scaled  = prod >>> ratioSel;
    sum     = $signed({{(PW - W){1'b0}}, aNext}) + scaled;
    blended = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segA   <= '0;
      segB   <= '0;
      code   <= '0;
      update <= 1'b0;
    end else begin
      update <= strobe.step;
      if (strobe.pop) begin
        segA <= aNext;
        segB <= bNext;
      end
      if (strobe.step)           code <= blended;
      else if (strobe.loadStatic) code <= staticCode;
    end
  end
endmodule

// File: rtl/dac_playout.sv
module dac_playout
  import dac_playout_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int DIV_W = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [W-1:0]           wrData,
  input  logic                   enable,
  input  logic [1:0]             playMode,
  input  logic [W-1:0]           staticCode,
  input  logic [CNT_W-1:0]       sampleCount,
  input  logic [DIV_W-1:0]       rateDiv,
  input  logic [RATIO_SEL_W-1:0] ratioSel,
  input  logic [LW-1:0]          lowMark,
  output logic [W-1:0]           code,
  output logic                   update,
  output logic                   done,
  output logic                   underrun,
  output logic                   fifoEmpty,
  output logic                   fifoFull,
  output logic                   fifoLow
);
  seqStrobe_t    strobe;
  logic [W-1:0]  rdData;
  logic [LW-1:0] level;

  assign fifoLow = (level < lowMark);

  dac_playout_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(strobe.pop), .rdData(rdData), .level(level),
    .empty(fifoEmpty), .full(fifoFull)
  );

  dac_playout_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .playMode(playMode),
    .sampleCount(sampleCount), .rateDiv(rateDiv), .ratioSel(ratioSel),
    .fifoEmpty(fifoEmpty), .strobe(strobe), .done(done), .underrun(underrun)
  );

  dac_playout_dpath #(.W(W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ratioSel(ratioSel),
    .staticCode(staticCode), .rdData(rdData), .code(code), .update(update)
  );
endmodule

// File: rtl/dac_playout_chk.sv
module dac_playout_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic [1:0]   playMode,
  input logic [W-1:0] code,
  input logic         update,
  input logic         done,
  input logic         underrun,
  input logic         fifoEmpty,
  input logic         fifoFull
);
  // R2: the FIFO cannot be empty and full at once
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  // R4: static mode never strobes
  a_r4_static_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (playMode == 2'd0 && $past(playMode) == 2'd0) |-> !update);

  // R8: nothing is played after a fixed-count run completes
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !update);

  // R9: in playback the code only moves together with the strobe
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    (playMode != 2'd0 && $past(playMode) != 2'd0 && !update) |-> $stable(code));

  // R10: flags stay set while enabled
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && enable) |=> done);

  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && enable) |=> underrun);
endmodule

bind dac_playout dac_playout_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .playMode(playMode),
  .code(code), .update(update), .done(done), .underrun(underrun),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
);

// File: tb/test_dac_playout.sv
module test_dac_playout;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrData = '0;
  logic        enable = 1'b0;
  logic [1:0]  playMode = '0;
  logic [11:0] staticCode = '0;
  logic [15:0] sampleCount = '0;
  logic [15:0] rateDiv = '0;
  logic [1:0]  ratioSel = '0;
  logic [3:0]  lowMark = '0;
  logic [11:0] code;
  logic        update, done, underrun, fifoEmpty, fifoFull, fifoLow;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int nGot = 0;
  int got [64];
  int gotCyc [64];
  int gotDone [64];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_playout i_dac_playout (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .enable(enable),
    .playMode(playMode), .staticCode(staticCode), .sampleCount(sampleCount),
    .rateDiv(rateDiv), .ratioSel(ratioSel), .lowMark(lowMark),
    .code(code), .update(update), .done(done), .underrun(underrun),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoLow(fifoLow)
  );

  always @(negedge clk) begin
    if (rstN && update && nGot < 64) begin
      got[nGot]     = int'(code);
      gotCyc[nGot]  = cyc;
      gotDone[nGot] = int'(done);
      nGot++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int blend(input int a, input int b, input int k, input int sh);
    return a + (((b - a) * k) >>> sh);
  endfunction

  task automatic doReset();
    enable = 1'b0; wrEn = 1'b0; playMode = 2'd0; ratioSel = 2'd0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nGot = 0;
  endtask

  task automatic push(input int v);
    wrEn = 1'b1; wrData = 12'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    lowMark = 4'd2;
    doReset();
    chk("R1 code", int'(code), 0);
    chk("R1 update", int'(update), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 underrun", int'(underrun), 0);
    chk("R1 empty", int'(fifoEmpty), 1);
    chk("R1 full", int'(fifoFull), 0);
    chk("R3 low at level 0 mark 2", int'(fifoLow), 1);
    push(5); push(6);
    chk("R3 low at level 2 mark 2", int'(fifoLow), 0);
    lowMark = 4'd3; #1;
    chk("R3 low at level 2 mark 3", int'(fifoLow), 1);
  endtask

  task automatic t_stream();
    int vals [8];
    doReset();
    lowMark = 4'd4;
    for (int i = 0; i < 8; i++) begin
      vals[i] = 500 * i + 7;
      push(vals[i]);
    end
    chk("R2 full at 8", int'(fifoFull), 1);
    chk("R2 not empty", int'(fifoEmpty), 0);
    chk("R3 not low at 8", int'(fifoLow), 0);
    push(4095);
    playMode = 2'd2; ratioSel = 2'd0; rateDiv = 16'd3;
    enable = 1'b1;
    repeat (8 * 4 + 20) @(negedge clk);
    chk("R2 R6 update count", nGot, 8);
    for (int i = 0; i < 8; i++) chk("R2 R6 sample order", got[i], vals[i]);
    for (int i = 1; i < 8; i++) chk("R5 spacing", gotCyc[i] - gotCyc[i-1], 4);
    chk("R9 underrun", int'(underrun), 1);
    chk("R9 code held", int'(code), vals[7]);
    chk("R2 drained", int'(fifoEmpty), 1);
    push(33); push(4000);
    repeat (20) @(negedge clk);
    chk("R9 resume count", nGot, 10);
    chk("R9 resume a", got[8], 33);
    chk("R9 resume b", got[9], 4000);
    chk("R10 underrun sticky", int'(underrun), 1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 underrun cleared", int'(underrun), 0);
  endtask

  task automatic t_static();
    doReset();
    push(1); push(2); push(3);
    playMode = 2'd0; staticCode = 12'h5A5; enable = 1'b1;
    repeat (30) @(negedge clk);
    chk("R4 static code", int'(code), 12'h5A5);
    chk("R4 no update", nGot, 0);
    staticCode = 12'h123;
    @(negedge clk);
    chk("R4 follows", int'(code), 12'h123);
    push(4); push(5); push(6); push(7); push(8);
    chk("R4 no reads, full", int'(fifoFull), 1);
    enable = 1'b0;
  endtask

  task automatic t_count_x4();
    int idx, prev, smp [2];
    doReset();
    smp[0] = 400; smp[1] = 800;
    push(400); push(800); push(1200);
    playMode = 2'd1; sampleCount = 16'd2; ratioSel = 2'd2; rateDiv = 16'd2;
    enable = 1'b1;
    repeat (80) @(negedge clk);
    chk("R7 R8 updates 2x4", nGot, 8);
    idx = 0; prev = 0;
    for (int s = 0; s < 2; s++) begin
      for (int k = 1; k <= 4; k++) begin
        chk("R7 ratio4 blend", got[idx], blend(prev, smp[s], k, 2));
        idx++;
      end
      prev = smp[s];
    end
    chk("R8 done with last", gotDone[7], 1);
    chk("R8 not done before", gotDone[6], 0);
    chk("R8 done level", int'(done), 1);
    chk("R8 one sample left", int'(fifoEmpty), 0);
    for (int i = 1; i < 8; i++) chk("R5 spacing ratio4", gotCyc[i] - gotCyc[i-1], 3);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 done cleared", int'(done), 0);
  endtask

  task automatic t_count_edge();
    doReset();
    push(10); push(20); push(30);
    playMode = 2'd1; sampleCount = 16'd0; ratioSel = 2'd0; rateDiv = 16'd1;
    enable = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 zero count done", int'(done), 1);
    chk("R8 zero count no update", nGot, 0);
    chk("R8 zero count no read", int'(fifoEmpty), 0);
    enable = 1'b0;
    @(negedge clk);
    sampleCount = 16'd3; nGot = 0;
    enable = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8 ratio1 count", nGot, 3);
    chk("R8 ratio1 last value", got[2], 30);
    chk("R8 ratio1 done with last", gotDone[2], 1);
    chk("R8 ratio1 empty", int'(fifoEmpty), 1);
    chk("R8 no underrun after done", int'(underrun), 0);
    enable = 1'b0;
  endtask

  task automatic t_interp(input int sel, input int a0, input int a1, input int a2);
    int smp [3];
    int n, idx, prev;
    doReset();
    smp[0] = a0; smp[1] = a1; smp[2] = a2;
    n = 1 << sel;
    push(a0); push(a1); push(a2);
    playMode = 2'd3; ratioSel = 2'(sel); rateDiv = 16'd1;
    enable = 1'b1;
    repeat (3 * n * 2 + 20) @(negedge clk);
    chk("R7 steps per sample", nGot, 3 * n);
    idx = 0; prev = 0;
    for (int s = 0; s < 3; s++) begin
      for (int k = 1; k <= n; k++) begin
        chk("R7 blend", got[idx], blend(prev, smp[s], k, sel));
        idx++;
      end
      prev = smp[s];
    end
    chk("R9 underrun after stream", int'(underrun), 1);
    enable = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_static();
    t_count_x4();
    t_count_edge();
    t_interp(3, 100, 3, 4095);
    t_interp(1, 4095, 0, 2048);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule